// File: doc/BRIEF.md
# Motion-adaptive recursive temporal noise filter

This block reduces random noise in a digital video stream by blending each incoming 8-bit luminance and chrominance sample with the co-sited sample from one field earlier. The delayed sample arrives on a back-channel bus from an external field memory, which is not part of this block. The blend weight K is picked per pixel from a fixed coefficient table. Noise is uncorrelated from one field to the next, so a K below one attenuates it. A K of one passes the live sample through unchanged.

Two pieces of information drive the choice of K. The first is a noise class (0, 1 or 2) that is measured once per field on one blanking-interval line. The second is a per-pixel motion level taken from the luminance frame difference. A larger motion level gives a larger K, which limits smearing of moving detail. Control inputs can do four things: switch filtering off, freeze the noise adaptation for tape sources, force a class or a table index for test, and leave the left half of each line unfiltered so the two halves can be compared side by side.

Top module: `tnr_filter`

## Requirements
- R1: While rst is high, and on the first clock after it, y_out and uv_out are 0. The measured noise class resets to 0.
- R2: Each clock, y_out becomes prev + floor((K16*(cur - prev) + 8) / 16), using the values on the ports at the previous rising edge. Here cur is y_in, prev is y_back and K16 is K in sixteenths (1..16). The result is bounded by cur and prev.
- R3: With nr_en = 0, K16 = 16, so y_out and uv_out equal the y_in and uv_in of one clock earlier.
- R4: The motion level is computed from d = |y_in - y_back|. It is 0 for d < 8, 1 for d < 16, 2 for d < 32 and 3 otherwise. In automatic operation the table index is class*4 + (3 - level).
- R5: Table entries 0..15 in sixteenths are 16, 12, 10, 9, 12, 8, 6, 5, 10, 6, 4, 3, 9, 5, 3, 2.
- R6: After a rising edge of vsync, each rising edge of blank_n starts the next line, and the first line is 1. On line 6 the block takes the mean absolute luminance difference over active pixels 0..31, using floor division and saturating at 31. A mean below thr_lo gives class 0, a mean below thr_hi gives class 1, and any other mean gives class 2. The new class is used from pixel 32 of that line on.
- R7: With vcr_mode = 1, the automatic class in use is 0 and the line-6 measurement does not change the stored class.
- R8: With force_cls_en = 1, force_cls replaces the automatic class, overriding vcr_mode. The value 3 acts as class 2.
- R9: With force_k_en = 1, force_k is used directly as the table index. This overrides class and motion.
- R10: With split_en = 1, active pixels 0 .. ACTIVE_PIX/2-1 use K16 = 16, counted from the first clock with blank_n high. The right half and the blanking cycles are filtered normally.
- R11: uv_out is produced by the same blend law as y_out, using uv_in, uv_back and the K that the luminance chose.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| blank_n | input | 1 | Line blanking, low during blanking, high for active pixels |
| vsync | input | 1 | Vertical sync, a rising edge restarts line counting |
| nr_en | input | 1 | Noise reduction enable |
| split_en | input | 1 | Leave the left half of each line unfiltered |
| vcr_mode | input | 1 | Freeze noise adaptation and use class 0 |
| force_cls_en | input | 1 | Use force_cls as the noise class |
| force_cls | input | 2 | Forced noise class |
| force_k_en | input | 1 | Use force_k as the table index |
| force_k | input | 4 | Forced coefficient table index |
| thr_lo | input | 5 | Lower class threshold (class 0 / class 1) |
| thr_hi | input | 5 | Upper class threshold (class 1 / class 2) |
| y_in | input | 8 | Live luminance sample |
| uv_in | input | 8 | Live chrominance sample |
| y_back | input | 8 | Luminance from one field earlier |
| uv_back | input | 8 | Chrominance from one field earlier |
| y_out | output | 8 | Filtered luminance, registered |
| uv_out | output | 8 | Filtered chrominance, registered |

## Verification
Every output sample is compared against a model in the next clock, so a wrong K shows as a wrong output value on the very pixel where it occurs. A wrong stored class stays hidden until a pixel's motion level selects a table entry that differs between classes. The stimulus therefore cycles through all four motion levels on every line, and a stale class shows within a few pixels after sample 31 of line 6. A pixel or line counter that is off by one moves the split boundary or the measurement window, so the mismatches cluster at pixel 32 or on lines 6 and 7.

// File: rtl/tnr_pkg.sv
package tnr_pkg;
  localparam int KW = 5;
  typedef logic [1:0] nclass_t;

  function automatic logic [KW-1:0] coef16(input logic [3:0] idx);
    logic [KW-1:0] k;
    case (idx)
      4'd0: k = 5'd16;  4'd1: k = 5'd12;  4'd2: k = 5'd10;  4'd3: k = 5'd9;
      4'd4: k = 5'd12;  4'd5: k = 5'd8;   4'd6: k = 5'd6;   4'd7: k = 5'd5;
      4'd8: k = 5'd10;  4'd9: k = 5'd6;   4'd10: k = 5'd4;  4'd11: k = 5'd3;
      4'd12: k = 5'd9;  4'd13: k = 5'd5;  4'd14: k = 5'd3;  default: k = 5'd2;
    endcase
    return k;
  endfunction
endpackage

// File: rtl/tnr_timing.sv
module tnr_timing #(
  parameter int ACTIVE_PIX = 720,
  parameter int PIX_W      = 10,
  parameter int LINE_W     = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              blank_n,
  input  logic              vsync,
  output logic [PIX_W-1:0]  pix_cnt,
  output logic [LINE_W-1:0] line_now,
  output logic              left_half
);
  localparam logic [PIX_W-1:0]  PIX_MAX = PIX_W'(ACTIVE_PIX);
  localparam logic [PIX_W-1:0]  HALF    = PIX_W'(ACTIVE_PIX / 2);
  localparam logic [LINE_W-1:0] LMAX    = {LINE_W{1'b1}};

  logic              blank_d, vs_d;
  logic [PIX_W-1:0]  pix_q;
  logic [LINE_W-1:0] line_q;
  logic              line_rise, vs_rise;

  assign line_rise = blank_n & ~blank_d;
  assign vs_rise   = vsync & ~vs_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      blank_d <= 1'b0;
      vs_d    <= 1'b0;
      pix_q   <= '0;
      line_q  <= '0;
    end else begin
      blank_d <= blank_n;
      vs_d    <= vsync;
      if (!blank_n)            pix_q <= '0;
      else if (pix_q != PIX_MAX) pix_q <= pix_q + 1'b1;
      if (vs_rise)                        line_q <= '0;
      else if (line_rise && line_q != LMAX) line_q <= line_q + 1'b1;
    end
  end

  assign pix_cnt   = pix_q;
  assign line_now  = (line_rise && line_q != LMAX) ? line_q + 1'b1 : line_q;
  assign left_half = blank_n && (pix_q < HALF);

  // R10: the first active clock of a line is pixel 0
  a_r10_first_pixel: assert property (@(posedge clk) disable iff (rst)
    $rose(blank_n) |-> (pix_q == '0));
endmodule

// File: rtl/tnr_noise_class.sv
module tnr_noise_class
  import tnr_pkg::*;
#(
  parameter int DW        = 8,
  parameter int PIX_W     = 10,
  parameter int LINE_W    = 10,
  parameter int TH_W      = 5,
  parameter int MEAS_LINE = 6,
  parameter int MEAS_LOG2 = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              blank_n,
  input  logic [PIX_W-1:0]  pix_cnt,
  input  logic [LINE_W-1:0] line_now,
  input  logic              vcr_mode,
  input  logic [TH_W-1:0]   thr_lo,
  input  logic [TH_W-1:0]   thr_hi,
  input  logic [DW-1:0]     y_in,
  input  logic [DW-1:0]     y_back,
  output nclass_t           cls
);
  localparam int                ACC_W  = DW + MEAS_LOG2;
  localparam logic [PIX_W-1:0]  NLAST  = PIX_W'((1 << MEAS_LOG2) - 1);
  localparam logic [LINE_W-1:0] MLINE  = LINE_W'(MEAS_LINE);
  localparam logic [ACC_W-1:0]  SATV   = ACC_W'({TH_W{1'b1}});

  logic [ACC_W-1:0] acc, sum, mean_full;
  logic [DW-1:0]    d;
  logic [TH_W-1:0]  mean;
  logic             window, last;
  nclass_t          cls_q;

  assign d         = (y_in >= y_back) ? y_in - y_back : y_back - y_in;
  assign window    = blank_n && (line_now == MLINE) && (pix_cnt <= NLAST);
  assign last      = window && (pix_cnt == NLAST);
  assign sum       = acc + ACC_W'(d);
  assign mean_full = sum >> MEAS_LOG2;
  assign mean      = (mean_full > SATV) ? {TH_W{1'b1}} : mean_full[TH_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc   <= '0;
      cls_q <= 2'd0;
    end else begin
      acc <= (window && !last) ? sum : '0;
      if (last && !vcr_mode) begin
        if (mean < thr_lo)      cls_q <= 2'd0;
        else if (mean < thr_hi) cls_q <= 2'd1;
        else                    cls_q <= 2'd2;
      end
    end
  end

  assign cls = cls_q;

  // R6: only three classes exist
  a_r6_class_legal: assert property (@(posedge clk) disable iff (rst)
    cls_q != 2'd3);
  // R6: the class moves only at the end of the measurement window
  a_r6_class_hold: assert property (@(posedge clk) disable iff (rst)
    !last |=> $stable(cls_q));
  // R7: tape mode leaves the stored class untouched
  a_r7_vcr_hold: assert property (@(posedge clk) disable iff (rst)
    vcr_mode |=> $stable(cls_q));
endmodule

// File: rtl/tnr_coef_sel.sv
module tnr_coef_sel
  import tnr_pkg::*;
#(
  parameter int DW     = 8,
  parameter int MOT_T1 = 8,
  parameter int MOT_T2 = 16,
  parameter int MOT_T3 = 32
) (
  input  logic          nr_en,
  input  logic          split_en,
  input  logic          left_half,
  input  logic          vcr_mode,
  input  logic          force_cls_en,
  input  logic [1:0]    force_cls,
  input  logic          force_k_en,
  input  logic [3:0]    force_k,
  input  nclass_t       cls_meas,
  input  logic [DW-1:0] y_in,
  input  logic [DW-1:0] y_back,
  output logic [KW-1:0] k16
);
  localparam logic [DW-1:0] T1 = DW'(MOT_T1);
  localparam logic [DW-1:0] T2 = DW'(MOT_T2);
  localparam logic [DW-1:0] T3 = DW'(MOT_T3);

  logic [DW-1:0] d;
  logic [1:0]    mlev;
  nclass_t       cls_use;

  assign d = (y_in >= y_back) ? y_in - y_back : y_back - y_in;

  always_comb begin
    if (d < T1)      mlev = 2'd0;
    else if (d < T2) mlev = 2'd1;
    else if (d < T3) mlev = 2'd2;
    else             mlev = 2'd3;

    if (force_cls_en) cls_use = (force_cls == 2'd3) ? 2'd2 : force_cls;
    else if (vcr_mode) cls_use = 2'd0;
    else               cls_use = cls_meas;

    if (!nr_en)                     k16 = 5'd16;
    else if (split_en && left_half) k16 = 5'd16;
    else if (force_k_en)            k16 = coef16(force_k);
    else                            k16 = coef16({cls_use, ~mlev});
  end

  // R5: every selected weight is a table value in 1/16 .. 16/16
  always_comb begin
    a_r5_k_range: assert (k16 >= 5'd1 && k16 <= 5'd16);
  end
endmodule

// File: rtl/tnr_filter.sv
module tnr_filter
  import tnr_pkg::*;
#(
  parameter int DW         = 8,
  parameter int ACTIVE_PIX = 720,
  parameter int LINE_W     = 10,
  parameter int TH_W       = 5,
  parameter int MEAS_LINE  = 6,
  parameter int MEAS_LOG2  = 5,
  parameter int MOT_T1     = 8,
  parameter int MOT_T2     = 16,
  parameter int MOT_T3     = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            blank_n,
  input  logic            vsync,
  input  logic            nr_en,
  input  logic            split_en,
  input  logic            vcr_mode,
  input  logic            force_cls_en,
  input  logic [1:0]      force_cls,
  input  logic            force_k_en,
  input  logic [3:0]      force_k,
  input  logic [TH_W-1:0] thr_lo,
  input  logic [TH_W-1:0] thr_hi,
  input  logic [DW-1:0]   y_in,
  input  logic [DW-1:0]   uv_in,
  input  logic [DW-1:0]   y_back,
  input  logic [DW-1:0]   uv_back,
  output logic [DW-1:0]   y_out,
  output logic [DW-1:0]   uv_out
);
  localparam int PIX_W = $clog2(ACTIVE_PIX + 1);

  logic [PIX_W-1:0]  pix_cnt;
  logic [LINE_W-1:0] line_now;
  logic              left_half;
  nclass_t           cls_meas;
  logic [KW-1:0]     k16;

  tnr_timing #(.ACTIVE_PIX(ACTIVE_PIX), .PIX_W(PIX_W), .LINE_W(LINE_W)) u_timing (
    .clk(clk), .rst(rst), .blank_n(blank_n), .vsync(vsync),
    .pix_cnt(pix_cnt), .line_now(line_now), .left_half(left_half));

  tnr_noise_class #(.DW(DW), .PIX_W(PIX_W), .LINE_W(LINE_W), .TH_W(TH_W),
                    .MEAS_LINE(MEAS_LINE), .MEAS_LOG2(MEAS_LOG2)) u_noise (
    .clk(clk), .rst(rst), .blank_n(blank_n), .pix_cnt(pix_cnt), .line_now(line_now),
    .vcr_mode(vcr_mode), .thr_lo(thr_lo), .thr_hi(thr_hi),
    .y_in(y_in), .y_back(y_back), .cls(cls_meas));

  tnr_coef_sel #(.DW(DW), .MOT_T1(MOT_T1), .MOT_T2(MOT_T2), .MOT_T3(MOT_T3)) u_coef (
    .nr_en(nr_en), .split_en(split_en), .left_half(left_half), .vcr_mode(vcr_mode),
    .force_cls_en(force_cls_en), .force_cls(force_cls),
    .force_k_en(force_k_en), .force_k(force_k), .cls_meas(cls_meas),
    .y_in(y_in), .y_back(y_back), .k16(k16));

  function automatic logic [DW-1:0] blend(input logic [DW-1:0] c, input logic [DW-1:0] p,
                                          input logic [KW-1:0] k);
    logic signed [DW+1:0] diff;
    logic signed [DW+7:0] prod, half, step, tot;
    diff = $signed({2'b00, c}) - $signed({2'b00, p});
    prod = diff * $signed({1'b0, k});
    half = (DW+8)'(8);
    step = (prod + half) >>> 4;
    tot  = $signed({8'b0, p}) + step;
    return tot[DW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      y_out  <= '0;
      uv_out <= '0;
    end else begin
      y_out  <= blend(y_in, y_back, k16);
      uv_out <= blend(uv_in, uv_back, k16);
    end
  end

  // R2: the result lies between the live and the delayed sample
  a_r2_bounded: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((y_out >= $past(y_in) && y_out <= $past(y_back)) ||
              (y_out <= $past(y_in) && y_out >= $past(y_back))));
  // R3: filtering off passes the live samples through
  a_r3_bypass: assert property (@(posedge clk) disable iff (rst)
    !nr_en |=> (y_out == $past(y_in) && uv_out == $past(uv_in)));
  // R10: left half in split mode is unfiltered
  a_r10_split_left: assert property (@(posedge clk) disable iff (rst)
    (split_en && left_half) |=> (y_out == $past(y_in) && uv_out == $past(uv_in)));
endmodule

// File: tb/tnr_filter_tb.sv
module tnr_filter_tb;
  localparam int ACT = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic blank_n = 1'b0, vsync = 1'b0;
  logic nr_en = 1'b1, split_en = 1'b0, vcr_mode = 1'b0;
  logic force_cls_en = 1'b0, force_k_en = 1'b0;
  logic [1:0] force_cls = 2'd0;
  logic [3:0] force_k = 4'd0;
  logic [4:0] thr_lo = 5'd4, thr_hi = 5'd16;
  logic [7:0] y_in = 8'd0, uv_in = 8'd0, y_back = 8'd0, uv_back = 8'd0;
  logic [7:0] y_out, uv_out;

  always #4 clk = ~clk;

  tnr_filter #(.ACTIVE_PIX(ACT)) u_dut (
    .clk(clk), .rst(rst), .blank_n(blank_n), .vsync(vsync), .nr_en(nr_en),
    .split_en(split_en), .vcr_mode(vcr_mode), .force_cls_en(force_cls_en),
    .force_cls(force_cls), .force_k_en(force_k_en), .force_k(force_k),
    .thr_lo(thr_lo), .thr_hi(thr_hi), .y_in(y_in), .uv_in(uv_in),
    .y_back(y_back), .uv_back(uv_back), .y_out(y_out), .uv_out(uv_out));

  // pending controls, applied at the next driven cycle
  bit p_nr = 1, p_split = 0, p_vcr = 0, p_fce = 0, p_fke = 0;
  int p_fc = 0, p_fk = 0;
  int b_class = 0;
  string cur_tag = "R1";
  int total = 0, bad = 0;
  bit done = 0;

  int    exp_y[$];
  int    exp_uv[$];
  string exp_tag[$];

  function automatic int tabk(int i);
    int t[16] = '{16, 12, 10, 9, 12, 8, 6, 5, 10, 6, 4, 3, 9, 5, 3, 2};
    return t[i];
  endfunction

  function automatic int absd(int a, int b);
    return (a > b) ? a - b : b - a;
  endfunction

  function automatic int clampb(int v);
    return (v < 0) ? 0 : (v > 255) ? 255 : v;
  endfunction

  function automatic int blendm(int c, int p, int k);
    int m;
    m = (c - p) * k;
    return p + ((m + 8) >>> 4);
  endfunction

  function automatic int pick_k(bit act, int pix, int y, int yb);
    int d, lev, cls;
    if (!p_nr) return 16;
    if (p_split && act && pix < ACT / 2) return 16;
    if (p_fke) return tabk(p_fk);
    d = absd(y, yb);
    lev = (d < 8) ? 0 : (d < 16) ? 1 : (d < 32) ? 2 : 3;
    if (p_fce) cls = (p_fc == 3) ? 2 : p_fc;
    else if (p_vcr) cls = 0;
    else cls = b_class;
    return tabk(cls * 4 + 3 - lev);
  endfunction

  task automatic step(bit act, bit vs, int y, int yb, int uv, int uvb, int pix);
    int k;
    @(negedge clk);
    nr_en = p_nr; split_en = p_split; vcr_mode = p_vcr;
    force_cls_en = p_fce; force_cls = 2'(p_fc);
    force_k_en = p_fke; force_k = 4'(p_fk);
    blank_n = act; vsync = vs;
    y_in = 8'(y); y_back = 8'(yb); uv_in = 8'(uv); uv_back = 8'(uvb);
    k = pick_k(act, pix, y, yb);
    exp_y.push_back(blendm(y, yb, k));
    exp_uv.push_back(blendm(uv, uvb, k));
    exp_tag.push_back(cur_tag);
  endtask

  task automatic do_line(int ln, int noise);
    int deltas[8] = '{0, 5, -9, 12, -20, 31, -40, 70};
    int y, yb, uv, uvb, acc, m;
    acc = 0;
    for (int i = 0; i < 4; i++)
      step(0, 0, (i * 37) & 255, (i * 11 + 60) & 255, 90 + i, 70, -1);
    for (int p = 0; p < ACT; p++) begin
      if (ln == 6 && p < 32) begin
        yb = 100 + (p % 4) * 3;
        y  = (p % 2 == 1) ? yb + noise : yb - noise;
      end else begin
        yb = (p * 5 + ln * 17 + 23) & 255;
        y  = clampb(yb + deltas[p % 8]);
      end
      uvb = (p * 3 + ln * 29) & 255;
      uv  = clampb(uvb + deltas[(p + 3) % 8]);
      step(1, 0, y, yb, uv, uvb, p);
      if (ln == 6 && p < 32) acc += absd(y, yb);
      if (ln == 6 && p == 31 && !p_vcr) begin
        m = acc >> 5;
        if (m > 31) m = 31;
        b_class = (m < int'(thr_lo)) ? 0 : (m < int'(thr_hi)) ? 1 : 2;
      end
    end
  endtask

  task automatic start_frame();
    for (int i = 0; i < 3; i++) step(0, 1, 10, 10, 10, 10, -1);
    for (int i = 0; i < 2; i++) step(0, 0, 10, 10, 10, 10, -1);
  endtask

  task automatic frame_head(int noise, string tag);
    start_frame();
    for (int l = 1; l <= 6; l++) begin
      cur_tag = tag;
      do_line(l, noise);
    end
  endtask

  // monitor: one expected item per driven cycle
  always @(posedge clk) begin
    #2;
    if (exp_y.size() > 0) begin
      int ey, eu;
      string t;
      ey = exp_y.pop_front();
      eu = exp_uv.pop_front();
      t  = exp_tag.pop_front();
      total++;
      if (int'(y_out) != ey || int'(uv_out) != eu) begin
        bad++;
        $display("FAIL %s y_out actual=%0d expected=%0d, uv_out actual=%0d expected=%0d",
                 t, y_out, ey, uv_out, eu);
      end
    end
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog all requirements actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    y_in = 8'd55; uv_in = 8'd77; y_back = 8'd3; uv_back = 8'd9;
    repeat (4) @(negedge clk);
    total++;
    if (y_out != 8'd0 || uv_out != 8'd0) begin
      bad++;
      $display("FAIL R1 reset actual=%0d/%0d expected=0/0", y_out, uv_out);
    end
    rst = 1'b0;

    // frame 1: class 0 out of reset, then measured class 1
    frame_head(10, "R1");
    cur_tag = "R4"; do_line(7, 0);
    p_split = 1; cur_tag = "R10"; do_line(8, 0);
    p_split = 0;

    // frame 2: class 2, forced index, forced class
    frame_head(20, "R2");
    p_fke = 1; p_fk = 3; cur_tag = "R9"; do_line(7, 0);
    p_fk = 15; do_line(8, 0);
    p_fke = 0; p_fce = 1; p_fc = 0; cur_tag = "R8"; do_line(9, 0);
    p_fce = 0;

    // frame 3: mean exactly at lower threshold -> class 1; forced code 3; bypass
    frame_head(4, "R5");
    cur_tag = "R6"; do_line(7, 0);
    p_fce = 1; p_fc = 3; cur_tag = "R8"; do_line(8, 0);
    p_fce = 0; p_nr = 0; cur_tag = "R3"; do_line(9, 0);
    p_nr = 1;

    // frame 4: mean exactly at upper threshold -> class 2
    frame_head(16, "R2");
    cur_tag = "R6"; do_line(7, 0);

    // frame 5: low noise -> class 0, chroma follows luma K
    frame_head(3, "R2");
    cur_tag = "R11"; do_line(7, 0);

    // frame 6: tape mode ignores a noisy measurement
    p_vcr = 1;
    frame_head(20, "R7");
    p_vcr = 0; cur_tag = "R7"; do_line(7, 0);

    // frame 7: measured class 2, then tape mode uses class 0
    frame_head(20, "R6");
    p_vcr = 1; cur_tag = "R7"; do_line(7, 0);
    p_vcr = 0; p_split = 1; cur_tag = "R10"; do_line(8, 0);
    p_split = 0;

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule